// File: doc/BRIEF.md
# Clock Loss Power-Down Controller

This block watches a monitored processing clock from a free-running reference clock. When the monitored clock stops toggling, the block asks for a fully static power-down state. When edges return, it withdraws that request. The monitored domain holds only a toggle flop. Everything else runs in the reference domain: a synchroniser, an edge detector, an idle counter and a small presence state machine.

Two control inputs come from a register bank outside this block. Both are synchronous to the reference clock and both are zero after power-up. `force_pd` requests power-down unconditionally. `detect_off` stops a lost clock from causing power-down, although loss is still reported on `clk_present`. The power-down request is registered in the reference domain.

Top module: `clkloss_pd_ctrl`

## Requirements
- R1: While `ref_rst_n` is low (asynchronous, active low), and afterwards until a timeout is reached, `pd_req` is 0 and `clk_present` is 1.
- R2: `clk_present` falls after TIMEOUT_CYCLES (default 16) consecutive reference cycles in which no monitored edge was detected. It never falls while edges keep arriving.
- R3: Once the clock is lost, `clk_present` rises again after RESUME_EDGES (default 2) detected edges. The edge count restarts whenever TIMEOUT_CYCLES cycles pass without an edge.
- R4: `force_pd` = 1 sampled at a reference edge makes `pd_req` 1 after that edge, whether or not the clock is running.
- R5: With `detect_off` = 1, a lost clock does not raise `pd_req`; `clk_present` still reports 0.
- R6: At each reference edge, `pd_req` takes `force_pd | (~detect_off & ~clk_present)` as those stood just before the edge.
- R7: Each rising edge of `mon_clk` counts as one detected edge. A clock whose rising edges are spaced more than TIMEOUT_CYCLES reference cycles apart is declared lost and never declared present. One whose edges are spaced well inside the timeout stays present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| ref_rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mon_clk | input | 1 | Monitored processing clock |
| force_pd | input | 1 | Force power-down (reference domain) |
| detect_off | input | 1 | Disable loss-triggered power-down (reference domain) |
| pd_req | output | 1 | Registered static power-down request |
| clk_present | output | 1 | 1 while the monitored clock is considered running |

## Verification
On every cycle the assertions check four things: the power-down equation, the priority of force over disable, that presence falls only after a full idle window counted in the checker, and that presence rises only right after a detected edge. The bench's scenarios are needed to show the rest. These are the exact latency from stop to loss, the number of edges needed for recovery, and the restart of the recovery count for a clock slower than the timeout. The bench compares these against its reference model every cycle.

// File: rtl/clkloss_pkg.sv
package clkloss_pkg;
    typedef enum logic {
        CLK_RUNNING = 1'b0,
        CLK_GONE    = 1'b1
    } clk_state_e;
endpackage

// File: rtl/clkloss_mon_toggle.sv
module clkloss_mon_toggle (
    input  logic mon_clk,
    input  logic rst_n,
    output logic tog
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = ~tog_q;
    end

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    assign tog = tog_q;
endmodule

// File: rtl/clkloss_sync.sv
module clkloss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/clkloss_tracker.sv
module clkloss_tracker
    import clkloss_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 16,
    parameter int RESUME_EDGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic edge_seen,
    output logic lost
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam int RW = $clog2(RESUME_EDGES + 1);
    localparam logic [CW-1:0] IDLE_MAX  = CW'(TIMEOUT_CYCLES);
    localparam logic [CW-1:0] IDLE_LAST = CW'(TIMEOUT_CYCLES - 1);
    localparam logic [RW-1:0] RUN_LAST  = RW'(RESUME_EDGES - 1);

    typedef struct packed {
        clk_state_e      st;
        logic            prev;
        logic [CW-1:0]   idle;
        logic [RW-1:0]   run;
    } trk_t;

    trk_t st_d, st_q;
    logic edge_w, timeout_hit;

    always_comb begin
        st_d        = st_q;
        edge_w      = sync_in ^ st_q.prev;
        timeout_hit = !edge_w && (st_q.idle == IDLE_LAST);
        st_d.prev   = sync_in;

        if (edge_w)                  st_d.idle = '0;
        else if (st_q.idle != IDLE_MAX) st_d.idle = st_q.idle + 1'b1;

        case (st_q.st)
            CLK_RUNNING: begin
                st_d.run = '0;
                if (timeout_hit) st_d.st = CLK_GONE;
            end
            default: begin
                if (edge_w) begin
                    if (st_q.run == RUN_LAST) begin
                        st_d.st  = CLK_RUNNING;
                        st_d.run = '0;
                    end else begin
                        st_d.run = st_q.run + 1'b1;
                    end
                end else if (timeout_hit) begin
                    st_d.run = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st   <= CLK_RUNNING;
            st_q.prev <= 1'b0;
            st_q.idle <= '0;
            st_q.run  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign edge_seen = edge_w;
    assign lost      = (st_q.st == CLK_GONE);
endmodule

// File: rtl/clkloss_pd_ctrl.sv
module clkloss_pd_ctrl #(
    parameter int TIMEOUT_CYCLES = 16,
    parameter int RESUME_EDGES   = 2,
    parameter int SYNC_STAGES    = 2
) (
    input  logic ref_clk,
    input  logic ref_rst_n,
    input  logic mon_clk,
    input  logic force_pd,
    input  logic detect_off,
    output logic pd_req,
    output logic clk_present
);
    logic tog, tog_sync, edge_seen, lost;
    logic pd_d, pd_q;

    clkloss_mon_toggle u_tog (
        .mon_clk (mon_clk),
        .rst_n   (ref_rst_n),
        .tog     (tog)
    );

    clkloss_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .din   (tog),
        .dout  (tog_sync)
    );

    clkloss_tracker #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
        .RESUME_EDGES   (RESUME_EDGES)
    ) u_trk (
        .clk       (ref_clk),
        .rst_n     (ref_rst_n),
        .sync_in   (tog_sync),
        .edge_seen (edge_seen),
        .lost      (lost)
    );

    always_comb begin
        pd_d = force_pd | (~detect_off & lost);
    end

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) pd_q <= 1'b0;
        else            pd_q <= pd_d;
    end

    assign pd_req      = pd_q;
    assign clk_present = ~lost;
endmodule

// File: rtl/clkloss_pd_ctrl_chk.sv
module clkloss_pd_ctrl_chk #(
    parameter int TIMEOUT_CYCLES = 16
) (
    input logic ref_clk,
    input logic ref_rst_n,
    input logic force_pd,
    input logic detect_off,
    input logic pd_req,
    input logic clk_present,
    input logic edge_seen
);
    int gap_q;

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n)                    gap_q <= 0;
        else if (edge_seen)                gap_q <= 0;
        else if (gap_q < TIMEOUT_CYCLES)   gap_q <= gap_q + 1;
    end

    // R4
    a_r4_force_wins: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        force_pd |=> pd_req);

    // R5
    a_r5_detect_off_quiet: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (detect_off && !force_pd) |=> !pd_req);

    // R6
    a_r6_loss_requests_pd: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (!force_pd && !detect_off && !clk_present) |=> pd_req);

    // R2
    a_r2_loss_after_window: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $fell(clk_present) |-> (gap_q >= TIMEOUT_CYCLES));

    // R2
    a_r2_edge_keeps_present: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (clk_present && edge_seen) |=> clk_present);

    // R3
    a_r3_return_on_edge: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $rose(clk_present) |-> $past(edge_seen));
endmodule

bind clkloss_pd_ctrl clkloss_pd_ctrl_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) chk_i (
    .ref_clk     (ref_clk),
    .ref_rst_n   (ref_rst_n),
    .force_pd    (force_pd),
    .detect_off  (detect_off),
    .pd_req      (pd_req),
    .clk_present (clk_present),
    .edge_seen   (edge_seen)
);

// File: tb/clkloss_pd_ctrl_tb_top.sv
module clkloss_pd_ctrl_tb_top;
    localparam int TMO = 16;
    localparam int RES = 2;

    logic ref_clk = 1'b0, ref_rst_n = 1'b0, mon_clk = 1'b0;
    logic force_pd = 1'b0, detect_off = 1'b0;
    logic pd_req, clk_present;

    always #4 ref_clk = ~ref_clk;

    clkloss_pd_ctrl #(.TIMEOUT_CYCLES(TMO), .RESUME_EDGES(RES), .SYNC_STAGES(2)) dut_i (
        .ref_clk     (ref_clk),
        .ref_rst_n   (ref_rst_n),
        .mon_clk     (mon_clk),
        .force_pd    (force_pd),
        .detect_off  (detect_off),
        .pd_req      (pd_req),
        .clk_present (clk_present)
    );

    int errors = 0, checks = 0, cyc = 0;
    logic mon_run = 1'b0;
    int div = 1, divc = 0;
    logic mon_par;

    // monitored clock: edges land on reference falling edges
    always @(negedge ref_clk) begin
        if (mon_run) begin
            divc++;
            if (divc >= div) begin
                divc = 0;
                mon_clk = ~mon_clk;
            end
        end
    end

    always @(posedge mon_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) mon_par <= 1'b0;
        else            mon_par <= ~mon_par;
    end

    // behavioural reference model
    logic h0, h1, h2, lost_m, pd_m;
    int idle_m, run_m;

    always @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            h0 = 0; h1 = 0; h2 = 0;
            lost_m = 0; pd_m = 0; idle_m = 0; run_m = 0;
        end else begin
            logic e;
            e = (h1 != h2);
            pd_m = force_pd | (!detect_off & lost_m);
            if (!lost_m) begin
                if (!e && idle_m == TMO - 1) begin lost_m = 1; run_m = 0; end
            end else if (e) begin
                run_m++;
                if (run_m == RES) begin lost_m = 0; run_m = 0; end
            end else if (idle_m == TMO - 1) begin
                run_m = 0;
            end
            if (e) idle_m = 0;
            else if (idle_m < TMO) idle_m++;
            h2 = h1; h1 = h0; h0 = mon_par;
        end
    end

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge ref_clk) begin
        if (ref_rst_n) begin
            check("R6 pd_req vs model", pd_req, pd_m);
            check("R2 R3 clk_present vs model", clk_present, !lost_m);
        end
    end

    always @(posedge ref_clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge ref_clk);
    endtask

    initial begin
        wait_cyc(3);
        check("R1 pd_req in reset", pd_req, 1'b0);
        check("R1 clk_present in reset", clk_present, 1'b1);
        ref_rst_n = 1'b1;
        mon_run = 1'b1;
        wait_cyc(5);
        check("R1 pd_req after reset", pd_req, 1'b0);
        check("R1 clk_present after reset", clk_present, 1'b1);
        wait_cyc(30);
        check("R7 fast clock present", clk_present, 1'b1);

        mon_run = 1'b0;
        wait_cyc(10);
        check("R2 not lost before timeout", clk_present, 1'b1);
        wait_cyc(30);
        check("R2 lost after timeout", clk_present, 1'b0);
        check("R6 pd on loss", pd_req, 1'b1);

        mon_run = 1'b1;
        wait_cyc(15);
        check("R3 present after resume", clk_present, 1'b1);
        check("R3 pd released", pd_req, 1'b0);

        force_pd = 1'b1;
        wait_cyc(2);
        check("R4 forced with clock running", pd_req, 1'b1);
        check("R4 clock still present", clk_present, 1'b1);
        force_pd = 1'b0;
        wait_cyc(2);
        check("R4 release force", pd_req, 1'b0);

        detect_off = 1'b1;
        mon_run = 1'b0;
        wait_cyc(40);
        check("R5 loss still reported", clk_present, 1'b0);
        check("R5 no pd while disabled", pd_req, 1'b0);
        force_pd = 1'b1;
        wait_cyc(2);
        check("R4 force overrides disable", pd_req, 1'b1);
        force_pd = 1'b0;
        detect_off = 1'b0;
        wait_cyc(2);
        check("R6 pd on re-enable", pd_req, 1'b1);

        div = 9; divc = 0;
        mon_run = 1'b1;
        wait_cyc(120);
        check("R7 slow clock stays lost", clk_present, 1'b0);
        check("R3 no resume with long gaps", pd_req, 1'b1);

        div = 3; divc = 0;
        wait_cyc(40);
        check("R7 moderate clock present", clk_present, 1'b1);
        check("R3 pd released at moderate rate", pd_req, 1'b0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule